// File: doc/BRIEF.md
# Multicast Doorbell Interrupt Controller

This block lets each of `N_CPU` processors raise an interrupt on any group of the other processors. Every processor owns a small local register port. Through that port it can ring a doorbell: it writes a mask with one bit per destination processor, and one write can reach any subset of them. Through the same port it can also read and acknowledge the requests waiting for it. Pending state is held as one bit for every ordered pair of caller and callee. Two processors that call the same target in the same cycle therefore each set their own bit, and neither request is lost.

A called processor reads its pending vector to see every caller with a request still open. It clears the callers it has handled by writing ones to their bit positions. Each processor has one interrupt line, which stays high while any bit of its pending vector is set. A caller can also read back which of its own doorbells have not yet been acknowledged. Payloads, priorities, vectoring and masking are handled elsewhere.

Top module: `ipi_doorbell_ctrl`

## Requirements
- R1: While `rst_ni` is low, every pending bit is cleared. After reset, all interrupt lines are low and every read returns zero.
- R2: Processor s writes with `addr_i[s]`=0 (doorbell) and sets bit t of its data field `wdata_i[s*N_CPU+t]`. On the next clock edge this sets pending bit s of target t.
- R3: A doorbell bit that names the writer itself (t equal to s) is ignored. No processor's pending vector changes because of it.
- R4: When several processors ring the same target in the same cycle, every caller's bit is recorded at that target.
- R5: Processor t writes with `addr_i[t]`=1 (acknowledge). On the next edge each one in its data field clears the pending bit of that sender position, and each zero leaves its bit unchanged.
- R6: If a doorbell set and an acknowledge clear hit the same pair in the same cycle, the bit ends up set.
- R7: `irq_o[t]` is high exactly while target t has at least one pending bit set. It rises only in the cycle after some processor rang t.
- R8: A read with `addr_i[c]`=1 returns on `rdata_o[c*N_CPU +: N_CPU]` the pending vector of c, with bit s set for caller s. A read with `addr_i[c]`=0 returns the doorbells of c that are still open, with bit t set while target t still holds c's request. Reads are combinational.
- R9: With `we_i[c]` low, the data and address of port c change no state. A doorbell for a bit that is already pending leaves that bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | N_CPU | Write enable, one per processor port |
| addr_i | input | N_CPU | Register select per port: 0 doorbell, 1 acknowledge/pending |
| wdata_i | input | N_CPU*N_CPU | Write data, field c belongs to port c |
| rdata_o | output | N_CPU*N_CPU | Read data, field c belongs to port c |
| irq_o | output | N_CPU | Interrupt line per processor |

## Verification
The bench sweeps every doorbell mask from every caller. It then drives all callers at once at a common target, and races a set against a clear on one pair. A design that kept one shared slot per target would drop callers in the simultaneous case. A design that let the clear win would lose a fresh request. A design that did not mask the diagonal would show processors calling themselves. Mixed random cycles then compare both read views and the interrupt lines against a matrix model in the bench, which catches transposed indexing between caller and target.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  typedef enum logic {
    REG_BELL = 1'b0,
    REG_ACK  = 1'b1
  } ipi_reg_e;
endpackage

// File: rtl/ipi_port_if.sv
module ipi_port_if
  import ipi_pkg::*;
#(
  parameter int N_CPU  = 4,
  parameter int CPU_ID = 0
) (
  input  logic             we_i,
  input  logic             addr_i,
  input  logic [N_CPU-1:0] wdata_i,
  input  logic [N_CPU-1:0] pend_row_i,
  input  logic [N_CPU-1:0] open_col_i,
  output logic [N_CPU-1:0] bell_o,
  output logic [N_CPU-1:0] ack_o,
  output logic [N_CPU-1:0] rdata_o
);
  localparam logic [N_CPU-1:0] SelfMask = N_CPU'(1) << CPU_ID;

  ipi_reg_e sel;
  assign sel = ipi_reg_e'(addr_i);

  always_comb begin
    bell_o = '0;
    ack_o  = '0;
    if (we_i && sel == REG_BELL) bell_o = wdata_i & ~SelfMask;
    if (we_i && sel == REG_ACK)  ack_o  = wdata_i;
  end

  assign rdata_o = (sel == REG_ACK) ? pend_row_i : open_col_i;
endmodule

// File: rtl/ipi_pend_row.sv
module ipi_pend_row #(
  parameter int N_CPU = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CPU-1:0] set_i,
  input  logic [N_CPU-1:0] clr_i,
  output logic [N_CPU-1:0] pend_o,
  output logic             irq_o
);
  logic [N_CPU-1:0] pend_q;

  // set after clear: a new request always survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;
  assign irq_o  = |pend_q;
endmodule

// File: rtl/ipi_doorbell_ctrl.sv
module ipi_doorbell_ctrl #(
  parameter int N_CPU = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_CPU-1:0]         we_i,
  input  logic [N_CPU-1:0]         addr_i,
  input  logic [N_CPU*N_CPU-1:0]   wdata_i,
  output logic [N_CPU*N_CPU-1:0]   rdata_o,
  output logic [N_CPU-1:0]         irq_o
);
  // pend[t][s]: target t holds a request from sender s
  logic [N_CPU-1:0][N_CPU-1:0] pend;
  logic [N_CPU-1:0][N_CPU-1:0] bell;   // bell[s][t]
  logic [N_CPU-1:0][N_CPU-1:0] ack;    // ack[t][s]
  logic [N_CPU-1:0][N_CPU-1:0] set_m;  // set_m[t][s]
  logic [N_CPU-1:0][N_CPU-1:0] open_m; // open_m[s][t]

  for (genvar r = 0; r < N_CPU; r++) begin : g_xpose
    for (genvar k = 0; k < N_CPU; k++) begin : g_bit
      assign set_m[r][k]  = bell[k][r];
      assign open_m[r][k] = pend[k][r];
    end
  end

  for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
    ipi_port_if #(
      .N_CPU (N_CPU),
      .CPU_ID(c)
    ) u_port (
      .we_i      (we_i[c]),
      .addr_i    (addr_i[c]),
      .wdata_i   (wdata_i[c*N_CPU +: N_CPU]),
      .pend_row_i(pend[c]),
      .open_col_i(open_m[c]),
      .bell_o    (bell[c]),
      .ack_o     (ack[c]),
      .rdata_o   (rdata_o[c*N_CPU +: N_CPU])
    );

    ipi_pend_row #(
      .N_CPU(N_CPU)
    ) u_row (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (set_m[c]),
      .clr_i (ack[c]),
      .pend_o(pend[c]),
      .irq_o (irq_o[c])
    );
  end
endmodule

// File: rtl/ipi_doorbell_ctrl_chk.sv
module ipi_doorbell_ctrl_chk #(
  parameter int N_CPU = 4
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic [N_CPU-1:0]               we_i,
  input logic [N_CPU-1:0]               addr_i,
  input logic [N_CPU*N_CPU-1:0]         wdata_i,
  input logic [N_CPU-1:0]               irq_o,
  input logic [N_CPU-1:0][N_CPU-1:0]    pend
);
  logic [N_CPU-1:0][N_CPU-1:0] want_set; // [t][s]
  logic [N_CPU-1:0][N_CPU-1:0] want_clr; // [t][s]

  always_comb begin
    for (int t = 0; t < N_CPU; t++) begin
      for (int s = 0; s < N_CPU; s++) begin
        want_set[t][s] = we_i[s] && !addr_i[s] && wdata_i[s*N_CPU+t] && (s != t);
        want_clr[t][s] = we_i[t] && addr_i[t] && wdata_i[t*N_CPU+s];
      end
    end
  end

  for (genvar t = 0; t < N_CPU; t++) begin : g_t
    // R7
    irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o[t]) |-> $past(|want_set[t]));

    // R3
    no_self_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pend[t][t] == 1'b0);

    for (genvar s = 0; s < N_CPU; s++) begin : g_s
      // R2
      set_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        want_set[t][s] |=> pend[t][s]);

      // R5
      clr_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (want_clr[t][s] && !want_set[t][s]) |=> !pend[t][s]);

      // R6
      set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (want_clr[t][s] && want_set[t][s]) |=> pend[t][s]);

      // R9
      hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!want_clr[t][s] && !want_set[t][s]) |=> $stable(pend[t][s]));
    end
  end
endmodule

bind ipi_doorbell_ctrl ipi_doorbell_ctrl_chk #(.N_CPU(N_CPU)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .we_i   (we_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .irq_o  (irq_o),
  .pend   (pend)
);

// File: tb/ipi_doorbell_ctrl_tb.sv
module ipi_doorbell_ctrl_tb;
  localparam int N = 4;
  localparam int W = N * N;

  logic         clk_i  = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] we_i   = '0;
  logic [N-1:0] addr_i = '0;
  logic [W-1:0] wdata_i = '0;
  logic [W-1:0] rdata_o;
  logic [N-1:0] irq_o;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] exp_m [N]; // exp_m[t][s]

  always #4 clk_i = ~clk_i;

  ipi_doorbell_ctrl #(.N_CPU(N)) u_dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o),
    .irq_o  (irq_o)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] want);
    checks++;
    if (act !== want) begin
      errors++;
      $display("FAIL %s act=%b exp=%b", tag, act, want);
    end
  endtask

  task automatic check_all(input string tag);
    logic [N-1:0] irq_w;
    logic [N-1:0] col;
    we_i   = '0;
    addr_i = '1;
    #1;
    for (int c = 0; c < N; c++)
      chk({tag, " R8 pending view"}, rdata_o[c*N +: N], exp_m[c]);
    for (int t = 0; t < N; t++) irq_w[t] = |exp_m[t];
    chk({tag, " R7 irq"}, irq_o, irq_w);
    addr_i = '0;
    #1;
    for (int c = 0; c < N; c++) begin
      for (int t = 0; t < N; t++) col[t] = exp_m[t][c];
      chk({tag, " R8 open doorbell view"}, rdata_o[c*N +: N], col);
    end
  endtask

  task automatic model(input logic [N-1:0] we_v, input logic [N-1:0] ad_v, input logic [W-1:0] wd_v);
    for (int t = 0; t < N; t++) begin
      for (int s = 0; s < N; s++) begin
        if (we_v[t] && ad_v[t] && wd_v[t*N+s]) exp_m[t][s] = 1'b0;
        if (we_v[s] && !ad_v[s] && wd_v[s*N+t] && s != t) exp_m[t][s] = 1'b1;
      end
    end
  endtask

  task automatic drive(input logic [N-1:0] we_v, input logic [N-1:0] ad_v, input logic [W-1:0] wd_v);
    @(negedge clk_i);
    we_i = we_v; addr_i = ad_v; wdata_i = wd_v;
    @(posedge clk_i);
    model(we_v, ad_v, wd_v);
    #1;
  endtask

  task automatic clear_all();
    drive('1, '1, '1);
    check_all("R5 clear all");
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int t = 0; t < N; t++) exp_m[t] = '0;
    #10;
    check_all("R1 in reset");
    @(negedge clk_i) rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check_all("R1 after reset");

    // R2 R3: every mask from every caller
    for (int s = 0; s < N; s++) begin
      for (int m = 0; m < (1 << N); m++) begin
        logic [W-1:0] wd;
        wd = '0;
        wd[s*N +: N] = N'(m);
        drive(N'(1) << s, '0, wd);
        check_all("R2 R3 sweep");
        clear_all();
      end
    end

    // R3: pure self ring
    drive(4'b0100, '0, W'(4'b0100) << (2*N));
    chk("R3 self ring irq", irq_o, '0);
    check_all("R3 self ring");

    // R4: all callers hit target 0 together, then all hit all
    drive('1, '0, {N{4'b0001}});
    chk("R4 target 0 sees callers", exp_m[0], 4'b1110);
    check_all("R4 simultaneous");
    drive('1, '0, '1);
    check_all("R4 all to all");

    // R5: partial ack on target 0 keeps other callers
    drive(4'b0001, 4'b0001, W'(4'b0110));
    chk("R5 partial ack model", exp_m[0], 4'b1000);
    check_all("R5 partial ack");
    clear_all();

    // R6: caller 1 rings target 0 while target 0 acks caller 1
    drive(4'b0011, 4'b0001, (W'(4'b0001) << N) | W'(4'b0010));
    chk("R6 set wins model", exp_m[0], 4'b0010);
    check_all("R6 set vs clear");

    // R9: no write enable, repeated ring of a pending bit
    drive('0, 4'b0101, '1);
    check_all("R9 no enable");
    drive(4'b0010, '0, W'(4'b0001) << N);
    check_all("R9 re-ring pending");
    clear_all();

    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      logic [W-1:0] wd;
      wd = W'($urandom);
      drive(N'($urandom), N'($urandom), wd);
      check_all("R2 R5 R6 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule